// File: doc/BRIEF.md
# Conversion Sequencer with External Multiplexer Select

This block schedules start-of-conversion slots for a multi-channel converter and drives the select lines of an external analog multiplexer placed in front of it. Each of the sixteen slots is tied to one trigger input. A pulse on a trigger marks every slot tied to it as waiting. An arbiter picks the next slot to run. Slots below a programmable count form a fixed-priority group. The remaining slots are served in rotating order from a pointer. A served slot first runs its own sample window and then a conversion of fixed length. The next waiting slot starts its sample window straight after the conversion ends.

Each slot carries a channel code for the external multiplexer. The select output always takes the running slot's code when its sample window opens. A lookahead enable chooses when the select may change at other times. With lookahead off, the select holds its value between sample windows. With lookahead on, the select is moved early, one cycle into the conversion, to the code of the slot expected to run next. This gives the external multiplexer the whole conversion time to settle. A trigger that arrives for a slot that is still waiting is recorded in a sticky per-slot flag, which software clears by writing ones.

Top module: `adcseq_top`

## Requirements
- R1: A trigger pulse marks every slot whose trigger select equals that trigger index as waiting. Each waiting slot is served exactly once. A trigger that coincides with its slot being taken marks that slot waiting again.
- R2: Slots with index below `cfg_hipri_i` are high priority, and the lowest such index wins. A high-priority slot is served ahead of any other waiting slot. One that becomes waiting during a conversion does not cut that conversion short; it runs in the next sample window.
- R3: Among the other waiting slots, the first one found searching upward from the rotation pointer (with wrap) wins. Serving such a slot moves the pointer to the index after it. The pointer resets to 0.
- R4: The sample phase (`phase_o`=1) lasts the slot's window value plus one cycle. The conversion phase (`phase_o`=2) lasts CONV_CYC cycles. If a slot is waiting, its sample phase starts in the cycle right after the last conversion cycle; otherwise `phase_o` returns to 0 (idle).
- R5: `eoc_o` is high for one cycle, the cycle after the last conversion cycle, with `eoc_soc_o` holding the index of the slot just converted.
- R6: In the first cycle of every sample phase, in either mode, `extmux_o` equals that slot's 4-bit channel code.
- R7: With lookahead off, `extmux_o` changes only at the start of a sample phase.
- R8: With lookahead on, in the second conversion cycle `extmux_o` equals the channel code of the highest-priority waiting slot as seen in the first conversion cycle.
- R9: With lookahead on and no slot waiting at that point, `extmux_o` takes the code of slot 0 if `cfg_hipri_i` is non-zero; otherwise it takes the code of the slot at the rotation pointer.
- R10: The lookahead enable resets to 0. It is loaded from `ctl_presel_i` when `ctl_we_i` is high, and is visible on `presel_en_o` one cycle later.
- R11: A trigger for a slot that is already waiting, and is not being taken in that cycle, sets that slot's bit in `ovf_o`. The slot stays waiting and is served only once. A one in `ovf_w1c_i` clears the matching bit a cycle later; zeros leave bits unchanged.
- R12: After reset `phase_o` is 0, `busy_o`, `eoc_o` and `ovf_o` are 0, and `extmux_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | NTRIG | Trigger pulses |
| cfg_trigsel_i | input | NSLOT*TW | Trigger index per slot |
| cfg_acq_i | input | NSLOT*ACQW | Sample window per slot (cycles minus one) |
| cfg_extch_i | input | NSLOT*CHW | External multiplexer code per slot |
| cfg_hipri_i | input | SW+1 | Size of the fixed-priority group |
| ctl_we_i | input | 1 | Write strobe for the lookahead enable |
| ctl_presel_i | input | 1 | Lookahead enable write value |
| ovf_w1c_i | input | NSLOT | Write-one-to-clear for overflow flags |
| presel_en_o | output | 1 | Current lookahead enable |
| extmux_o | output | CHW | External multiplexer select |
| phase_o | output | 2 | 0 idle, 1 sample, 2 conversion |
| busy_o | output | 1 | High when not idle |
| cur_soc_o | output | SW | Slot in service |
| eoc_o | output | 1 | End-of-conversion pulse |
| eoc_soc_o | output | SW | Slot of the finished conversion |
| ovf_o | output | NSLOT | Sticky trigger-overflow flags |

## Verification
A trigger sampled at one edge marks its slots waiting at that edge. The first sample phase opens one edge later, and the new select code shows in that same cycle. The lookahead update appears in the second conversion cycle. The end pulse appears in the cycle after the last conversion cycle, and a flag write shows one cycle after its strobe. The bench drives inputs and samples outputs on falling edges. It follows `phase_o` cycle by cycle: it counts sample and conversion lengths, checks the select code at each of the cycles named above, and checks it against a list of expected slot orders and lookahead codes for four scenarios (lookahead on or off, with or without a late high-priority trigger).

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SAMP = 2'd1,
      PH_CONV = 2'd2
   } phase_e;
endpackage

// File: rtl/adcseq_pending.sv
module adcseq_pending #(
   parameter int NSLOT = 16,
   parameter int NTRIG = 4,
   localparam int SW = $clog2(NSLOT),
   localparam int TW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NTRIG-1:0]    trig_i,
   input  logic [NSLOT*TW-1:0] trigsel_i,
   input  logic                take_i,
   input  logic [SW-1:0]       take_idx_i,
   input  logic [NSLOT-1:0]    w1c_i,
   output logic [NSLOT-1:0]    pend_o,
   output logic [NSLOT-1:0]    ovf_o
);
   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic [TW-1:0] sel;
      logic          hit;
      logic          take;
      assign sel  = trigsel_i[i*TW +: TW];
      assign hit  = (int'(sel) < NTRIG) ? trig_i[sel] : 1'b0;
      assign take = take_i && (take_idx_i == SW'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_o[i] <= 1'b0;
            ovf_o[i]  <= 1'b0;
         end else begin
            pend_o[i] <= (pend_o[i] && !take) || hit;
            ovf_o[i]  <= (ovf_o[i] && !w1c_i[i]) || (hit && pend_o[i] && !take);
         end
      end

      // R11
      ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovf_o[i]) |-> $past(pend_o[i]));
   end
endmodule

// File: rtl/adcseq_arb.sv
module adcseq_arb #(
   parameter int NSLOT = 16,
   localparam int SW = $clog2(NSLOT)
) (
   input  logic [NSLOT-1:0] pend_i,
   input  logic [SW:0]      hp_n_i,
   input  logic [SW-1:0]    ptr_i,
   output logic             any_o,
   output logic [SW-1:0]    win_o,
   output logic [SW-1:0]    idle_o
);
   logic          hp_hit, rr_hit;
   logic [SW-1:0] hp_idx, rr_idx;

   always_comb begin
      hp_hit = 1'b0;
      hp_idx = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (pend_i[i] && ((SW+1)'(i) < hp_n_i)) begin
            hp_hit = 1'b1;
            hp_idx = SW'(i);
         end
      end
   end

   always_comb begin
      rr_hit = 1'b0;
      rr_idx = '0;
      for (int k = NSLOT - 1; k >= 0; k--) begin
         int s;
         s = int'(ptr_i) + k;
         if (s >= NSLOT) s = s - NSLOT;
         if (pend_i[s] && ((SW+1)'(s) >= hp_n_i)) begin
            rr_hit = 1'b1;
            rr_idx = SW'(s);
         end
      end
   end

   assign any_o  = hp_hit || rr_hit;
   assign win_o  = hp_hit ? hp_idx : rr_idx;
   assign idle_o = (hp_n_i != '0) ? '0 : ptr_i;
endmodule

// File: rtl/adcseq_muxdrv.sv
module adcseq_muxdrv #(
   parameter int CHW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic [CHW-1:0] load_ch_i,
   input  logic           pre_i,
   input  logic [CHW-1:0] pre_ch_i,
   output logic [CHW-1:0] mux_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      mux_o <= '0;
      else if (load_i) mux_o <= load_ch_i;
      else if (pre_i)  mux_o <= pre_ch_i;
   end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
   import adcseq_pkg::*;
#(
   parameter int NSLOT    = 16,
   parameter int NTRIG    = 4,
   parameter int ACQW     = 9,
   parameter int CHW      = 4,
   parameter int CONV_CYC = 8,
   localparam int SW   = $clog2(NSLOT),
   localparam int TW   = (NTRIG > 1) ? $clog2(NTRIG) : 1,
   localparam int CVW  = $clog2(CONV_CYC + 1),
   localparam int CNTW = (ACQW > CVW) ? ACQW : CVW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NTRIG-1:0]      trig_i,
   input  logic [NSLOT*TW-1:0]   cfg_trigsel_i,
   input  logic [NSLOT*ACQW-1:0] cfg_acq_i,
   input  logic [NSLOT*CHW-1:0]  cfg_extch_i,
   input  logic [SW:0]           cfg_hipri_i,
   input  logic                  ctl_we_i,
   input  logic                  ctl_presel_i,
   input  logic [NSLOT-1:0]      ovf_w1c_i,
   output logic                  presel_en_o,
   output logic [CHW-1:0]        extmux_o,
   output logic [1:0]            phase_o,
   output logic                  busy_o,
   output logic [SW-1:0]         cur_soc_o,
   output logic                  eoc_o,
   output logic [SW-1:0]         eoc_soc_o,
   output logic [NSLOT-1:0]      ovf_o
);
   if (NSLOT < 2 || (1 << SW) != NSLOT) begin : g_bad_nslot
      $error("NSLOT must be a power of two, at least 2");
   end
   if (CONV_CYC < 2) begin : g_bad_conv
      $error("CONV_CYC must be at least 2");
   end
   if (ACQW < 1 || CHW < 1) begin : g_bad_width
      $error("ACQW and CHW must be positive");
   end

   logic [ACQW-1:0] acq_w   [NSLOT];
   logic [CHW-1:0]  extch_w [NSLOT];
   for (genvar i = 0; i < NSLOT; i++) begin : g_unpack
      assign acq_w[i]   = cfg_acq_i[i*ACQW +: ACQW];
      assign extch_w[i] = cfg_extch_i[i*CHW +: CHW];
   end

   phase_e          phase_q;
   logic [CNTW-1:0] cnt_q;
   logic [SW-1:0]   cur_q, ptr_q, eoc_idx_q;
   logic            eoc_q, presel_q, pre_go_q;
   logic [NSLOT-1:0] pend_w;
   logic            any_w, start_w, last_conv_w, last_samp_w;
   logic [SW-1:0]   win_w, idle_w;

   adcseq_pending #(.NSLOT(NSLOT), .NTRIG(NTRIG)) u_pend (
      .clk, .rst_n, .trig_i, .trigsel_i(cfg_trigsel_i),
      .take_i(start_w), .take_idx_i(win_w), .w1c_i(ovf_w1c_i),
      .pend_o(pend_w), .ovf_o(ovf_o));

   adcseq_arb #(.NSLOT(NSLOT)) u_arb (
      .pend_i(pend_w), .hp_n_i(cfg_hipri_i), .ptr_i(ptr_q),
      .any_o(any_w), .win_o(win_w), .idle_o(idle_w));

   assign last_conv_w = (phase_q == PH_CONV) && (cnt_q == '0);
   assign last_samp_w = (phase_q == PH_SAMP) && (cnt_q == '0);
   assign start_w     = any_w && ((phase_q == PH_IDLE) || last_conv_w);

   adcseq_muxdrv #(.CHW(CHW)) u_mux (
      .clk, .rst_n,
      .load_i(start_w), .load_ch_i(extch_w[win_w]),
      .pre_i(pre_go_q && presel_q),
      .pre_ch_i(any_w ? extch_w[win_w] : extch_w[idle_w]),
      .mux_o(extmux_o));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         cur_q     <= '0;
         ptr_q     <= '0;
         eoc_q     <= 1'b0;
         eoc_idx_q <= '0;
         presel_q  <= 1'b0;
         pre_go_q  <= 1'b0;
      end else begin
         eoc_q    <= last_conv_w;
         pre_go_q <= last_samp_w;
         if (last_conv_w) eoc_idx_q <= cur_q;
         if (ctl_we_i)    presel_q  <= ctl_presel_i;
         if (start_w) begin
            phase_q <= PH_SAMP;
            cur_q   <= win_w;
            cnt_q   <= CNTW'(acq_w[win_w]);
            if ((SW+1)'(win_w) >= cfg_hipri_i) ptr_q <= win_w + SW'(1);
         end else if (last_conv_w) begin
            phase_q <= PH_IDLE;
         end else if (last_samp_w) begin
            phase_q <= PH_CONV;
            cnt_q   <= CNTW'(CONV_CYC - 1);
         end else if (phase_q != PH_IDLE) begin
            cnt_q <= cnt_q - CNTW'(1);
         end
      end
   end

   assign presel_en_o = presel_q;
   assign phase_o     = phase_q;
   assign busy_o      = (phase_q != PH_IDLE);
   assign cur_soc_o   = cur_q;
   assign eoc_o       = eoc_q;
   assign eoc_soc_o   = eoc_idx_q;

   // R5
   eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_q |=> !eoc_q);

   // R1
   served_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SAMP && $past(phase_q) != PH_SAMP)
      |-> ((($past(pend_w)) >> cur_q) & NSLOT'(1)) != '0);

   // R6
   mux_at_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SAMP && $past(phase_q) != PH_SAMP)
      |-> extmux_o == extch_w[cur_q]);

   // R7
   mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(presel_q) && !(phase_q == PH_SAMP && $past(phase_q) != PH_SAMP))
      |-> $stable(extmux_o));
endmodule

// File: tb/adcseq_top_test.sv
module adcseq_top_test;
   localparam int NSLOT = 16, NTRIG = 4, ACQW = 9, CHW = 4, CONV = 8;
   localparam int SW = 4, TW = 2, ACQ = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                  rst_n = 1'b0;
   logic [NTRIG-1:0]      drv_trig = '0;
   logic                  inj = 1'b0;
   logic [NTRIG-1:0]      trig_w;
   logic [NSLOT*TW-1:0]   trigsel;
   logic [NSLOT*ACQW-1:0] acqv;
   logic [NSLOT*CHW-1:0]  chv;
   logic [SW:0]           hipri = '0;
   logic                  ctl_we = 1'b0, ctl_presel = 1'b0;
   logic [NSLOT-1:0]      w1c = '0;
   logic                  presel_en, busy, eoc;
   logic [CHW-1:0]        extmux;
   logic [1:0]            phase;
   logic [SW-1:0]         cur, eoc_soc;
   logic [NSLOT-1:0]      ovf;

   assign trig_w = drv_trig | (inj ? 4'b0010 : 4'b0000);

   adcseq_top uut (
      .clk, .rst_n, .trig_i(trig_w), .cfg_trigsel_i(trigsel), .cfg_acq_i(acqv),
      .cfg_extch_i(chv), .cfg_hipri_i(hipri), .ctl_we_i(ctl_we),
      .ctl_presel_i(ctl_presel), .ovf_w1c_i(w1c), .presel_en_o(presel_en),
      .extmux_o(extmux), .phase_o(phase), .busy_o(busy), .cur_soc_o(cur),
      .eoc_o(eoc), .eoc_soc_o(eoc_soc), .ovf_o(ovf));

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int chan(input int i);
      return (i * 5 + 3) & 15;
   endfunction

   // scenario state
   int  exp_order [4];
   int  exp_pre   [4];
   int  n_exp = 0;
   bit  mode_pre = 1'b0, arm = 1'b0, mon_on = 1'b0;
   int  k = 0, k_eoc = 0, scnt = 0, ccnt = 0, conv_len = 0;
   int  prev_ph = 0, prev_mux = 0;
   bit  injected = 1'b0;

   always @(negedge clk) begin
      if (!mon_on) begin
         k = 0; k_eoc = 0; scnt = 0; ccnt = 0; conv_len = 0;
         prev_ph = 0; prev_mux = int'(extmux); injected = 1'b0; inj <= 1'b0;
      end else begin
         int  ph;
         bit  st;
         ph = int'(phase);
         st = (ph == 1) && (prev_ph != 1);
         inj <= 1'b0;
         if (st) begin
            chk(k < n_exp && int'(cur) == exp_order[k % 4], "R1 R2 R3 order",
                int'(cur), exp_order[k % 4]);
            chk(int'(extmux) == chan(int'(cur)), "R6 sample select", int'(extmux),
                chan(int'(cur)));
            k++;
            scnt = 1;
         end else if (ph == 1) scnt++;
         if (prev_ph == 1 && ph != 1)
            chk(scnt == ACQ + 1, "R4 sample length", scnt, ACQ + 1);
         if (ph == 2) begin
            ccnt = (prev_ph != 2) ? 1 : ccnt + 1;
            if (ccnt == 2 && mode_pre)
               chk(int'(extmux) == exp_pre[(k - 1) % 4], "R8 R9 lookahead",
                   int'(extmux), exp_pre[(k - 1) % 4]);
            if (arm && !injected && int'(cur) == 1 && ccnt == 4) begin
               inj <= 1'b1;
               injected = 1'b1;
            end
         end
         if (prev_ph == 2 && ph != 2) conv_len = ccnt;
         if (eoc) begin
            chk(int'(eoc_soc) == exp_order[k_eoc % 4], "R5 end index", int'(eoc_soc),
                exp_order[k_eoc % 4]);
            chk(conv_len == CONV, "R2 R4 conversion length", conv_len, CONV);
            k_eoc++;
            chk(k_eoc >= n_exp || ph == 1, "R4 no gap", ph, 1);
         end
         if (!mode_pre && !st)
            chk(int'(extmux) == prev_mux, "R7 select held", int'(extmux), prev_mux);
         prev_ph = ph;
         prev_mux = int'(extmux);
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_scen(input bit pre, input int hp, input bit a, input int trig_len,
                           input int fin_mux);
      mon_on = 1'b0;
      do_reset();
      chk(presel_en == 1'b0, "R10 reset value", int'(presel_en), 0);
      hipri = (SW+1)'(hp);
      mode_pre = pre;
      arm = a;
      ctl_we = 1'b1; ctl_presel = pre;
      @(negedge clk);
      ctl_we = 1'b0; ctl_presel = 1'b0;
      chk(presel_en == pre, "R10 write", int'(presel_en), int'(pre));
      mon_on = 1'b1;
      @(negedge clk);
      drv_trig = 4'b0001;
      repeat (trig_len) @(negedge clk);
      drv_trig = '0;
      for (int t = 0; t < 400 && k_eoc < n_exp; t++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(k == n_exp, "R1 serve count", k, n_exp);
      chk(phase == 2'd0 && !busy, "R4 idle after", int'(phase), 0);
      chk(int'(extmux) == fin_mux, "R7 R9 final select", int'(extmux), fin_mux);
      mon_on = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < NSLOT; i++) begin
         trigsel[i*TW +: TW] = (i == 1 || i == 2) ? 2'd0 : (i == 0) ? 2'd1 : 2'd3;
         acqv[i*ACQW +: ACQW] = ACQW'(ACQ);
         chv[i*CHW +: CHW]    = CHW'(chan(i));
      end
      do_reset();
      // R12
      chk(phase == 2'd0 && !busy && !eoc, "R12 idle", int'(phase), 0);
      chk(extmux == '0, "R12 select", int'(extmux), 0);
      chk(ovf == '0, "R12 flags", int'(ovf), 0);

      // A: lookahead off, no priority group, trigger held two cycles (R11, R3 wrap)
      n_exp = 3;
      exp_order = '{1, 2, 1, 0};
      exp_pre   = '{0, 0, 0, 0};
      run_scen(1'b0, 0, 1'b0, 2, chan(1));
      chk(ovf == 16'h0004, "R11 overflow flag", int'(ovf), 4);
      w1c = 16'h000B;
      @(negedge clk);
      w1c = '0;
      chk(ovf == 16'h0004, "R11 zero bits ignored", int'(ovf), 4);
      w1c = 16'h0004;
      @(negedge clk);
      w1c = '0;
      chk(ovf == '0, "R11 clear", int'(ovf), 0);

      // B: lookahead on, no priority group; idle guess from the pointer (R9)
      n_exp = 2;
      exp_order = '{1, 2, 0, 0};
      exp_pre   = '{chan(2), chan(3), 0, 0};
      run_scen(1'b1, 0, 1'b0, 1, chan(3));
      chk(ovf == '0, "R11 no overflow", int'(ovf), 0);

      // C: lookahead off, slot 0 high priority, late trigger (R2)
      n_exp = 3;
      exp_order = '{1, 0, 2, 0};
      exp_pre   = '{0, 0, 0, 0};
      run_scen(1'b0, 1, 1'b1, 1, chan(2));

      // D: lookahead on, slot 0 high priority, late trigger overrides guess (R8, R9)
      n_exp = 3;
      exp_order = '{1, 0, 2, 0};
      exp_pre   = '{chan(2), chan(2), chan(0), 0};
      run_scen(1'b1, 1, 1'b1, 1, chan(0));

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule